// File: doc/BRIEF.md
# Store Queue with Read-Miss Forwarding

This block sits between a write-through cache and the next memory level. It takes processor stores into a small first-in first-out queue. A store is accepted in a single handshake, so the processor can move on at once. The queue then sends the stores to memory one at a time, in the order they arrived. The memory port uses a valid/ready request channel and a separate read-data return.

A read miss from the cache is first compared with every store still waiting in the queue. If any pending store has the same address, the read is answered from the queue, and the youngest matching store supplies the data. This means the read can never see a memory value that an older store has not yet overwritten. If nothing matches, the read goes to memory ahead of the queued stores. The exception is a store that has already been presented to memory and not yet accepted: that store finishes first.

A static configuration input selects a more conservative mode. In that mode, an unmatched read waits until the queue has fully drained before it goes to memory.

Top module: `wbuf_fwd`

## Requirements
- R1: After reset the queue is empty, `st_ready` and `rd_ready` are 1, and `mem_valid` and `rsp_valid` are 0.
- R2: `st_ready` is 1 whenever fewer than DEPTH stores are pending, and 0 when DEPTH are pending. A store offered while the queue is full waits until a drain frees a slot.
- R3: Pending stores leave in arrival order. Each drain is one memory request with `mem_we`=1, carrying the address and data of the oldest pending store. That store is removed in the cycle `mem_ready` is 1.
- R4: Once `mem_valid` is 1 and `mem_ready` is 0, the next cycle shows the same request: `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` are unchanged.
- R5: A read accepted while a pending store has the same address gives `rsp_valid`=1 in the next cycle, with the data of the youngest matching store. No memory read is issued for it.
- R6: In normal mode (`hold_rd_empty`=0), a read with no match is issued to memory (`mem_we`=0) in the cycle after it is accepted, even while stores are pending. The only exception is a drain that is already presented and not yet accepted, which completes first.
- R7: While a memory read is outstanding, no drain is presented. The cycle after `mem_rvalid` is 1, `rsp_valid` is 1 and `rsp_data` equals the `mem_rdata` of that cycle.
- R8: When `hold_rd_empty`=1, an unmatched read is not issued to memory until the queue is empty. Drains continue while the read waits.
- R9: `rd_ready` is 0 from the cycle after an unmatched read is accepted until the cycle after its response. A store accepted in the same cycle as a read is not visible to that read's search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_rd_empty | input | 1 | Static mode: 1 makes an unmatched read wait for an empty queue |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| rd_valid | input | 1 | Read miss offered |
| rd_ready | output | 1 | Read miss can be accepted |
| rd_addr | input | ADDR_W | Read miss address |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_data | output | DATA_W | Read data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 for a drain write, 0 for a read |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Drain data (0 on a read) |
| mem_rvalid | input | 1 | Memory read data returned |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
A queue filled with a stalled memory, holding repeated addresses, checks that a forwarded read gets the youngest matching store and not an older one. An unmatched read issued against a partly full queue shows whether the read overtakes the drains or waits behind them, and the same pattern under the hold mode must show the opposite outcome. After the drain, reading an address that several stores hit confirms that memory ends up with the last store, so the drain order is correct. Long mixed runs use a randomly stalling memory and concurrent stores and reads, including reads in the same cycle as stores. These runs exercise lock-in of a presented request and visibility of same-cycle stores.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    // Read-miss handling phase
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,   // ready to accept a read miss
        RD_ISSUE = 2'd1,   // unmatched read waiting for the memory port
        RD_WAIT  = 2'd2    // read accepted by memory, waiting for data
    } rd_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
// Circular store queue. Entries are exposed oldest-first so that the
// search logic can give priority to the youngest matching entry.
module wbuf_fifo #(
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic          empty,
    output logic          ord_vld  [DEPTH],
    output logic [AW-1:0] ord_addr [DEPTH],
    output logic [DW-1:0] ord_data [DEPTH]
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0]                head;
        logic [CW-1:0]                cnt;
        logic [DEPTH-1:0][AW-1:0]     addr;
        logic [DEPTH-1:0][DW-1:0]     data;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    function automatic logic [PW-1:0] slot(input int unsigned base, input int unsigned off);
        int unsigned s;
        s = (base + off) % DEPTH;
        return s[PW-1:0];
    endfunction

    logic [PW-1:0] tail;
    assign tail  = slot(int'(st_q.head), int'(st_q.cnt));
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.addr[tail] = push_addr;
            st_d.data[tail] = push_data;
        end
        if (pop) begin
            st_d.head = slot(int'(st_q.head), 1);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Age-ordered view: position 0 is the oldest pending store
    for (genvar i = 0; i < DEPTH; i++) begin : g_ord
        logic [PW-1:0] idx;
        assign idx         = slot(int'(st_q.head), i);
        assign ord_addr[i] = st_q.addr[idx];
        assign ord_data[i] = st_q.data[idx];
        assign ord_vld[i]  = (CW'(i) < st_q.cnt);
    end
endmodule

// File: rtl/wbuf_match.sv
// Parallel address compare over all pending stores; a later (younger)
// entry overrides an earlier match.
module wbuf_match #(
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic          ord_vld  [DEPTH],
    input  logic [AW-1:0] ord_addr [DEPTH],
    input  logic [DW-1:0] ord_data [DEPTH],
    input  logic [AW-1:0] q_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data
);
    logic          hit_c [DEPTH+1];
    logic [DW-1:0] dat_c [DEPTH+1];

    assign hit_c[0] = 1'b0;
    assign dat_c[0] = '0;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic m;
        assign m            = ord_vld[i] && (ord_addr[i] == q_addr);
        assign hit_c[i+1]   = hit_c[i] | m;
        assign dat_c[i+1]   = m ? ord_data[i] : dat_c[i];
    end

    assign hit      = hit_c[DEPTH];
    assign hit_data = dat_c[DEPTH];
endmodule

// File: rtl/wbuf_port.sv
// Read-miss sequencing and memory-port arbitration between an unmatched
// read and the queue drain.
module wbuf_port
    import wbuf_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_rd_empty,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ready,
    input  logic          hit,
    input  logic [DW-1:0] hit_data,
    input  logic          q_empty,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    output logic          pop,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    typedef struct packed {
        rd_state_e     rs;
        logic [AW-1:0] raddr;
        logic          lock_wr;   // drain presented, not yet accepted
        logic          lock_rd;   // read presented, not yet accepted
        logic          rsp_v;
        logic [DW-1:0] rsp_d;
    } port_st_t;

    port_st_t st_q, st_d;
    logic read_go, drain_go;

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;

        read_go  = (st_q.rs == RD_ISSUE) &&
                   (st_q.lock_rd || (!st_q.lock_wr && !(hold_rd_empty && !q_empty)));
        drain_go = !q_empty && (st_q.rs != RD_WAIT) && !read_go;

        mem_valid = read_go || drain_go;
        mem_we    = drain_go;
        mem_addr  = read_go ? st_q.raddr : head_addr;
        mem_wdata = drain_go ? head_data : '0;
        pop       = drain_go && mem_ready;

        st_d.lock_wr = drain_go && !mem_ready;
        st_d.lock_rd = read_go && !mem_ready;

        unique case (st_q.rs)
            RD_IDLE: begin
                if (rd_valid) begin
                    if (hit) begin
                        st_d.rsp_v = 1'b1;
                        st_d.rsp_d = hit_data;
                    end else begin
                        st_d.rs    = RD_ISSUE;
                        st_d.raddr = rd_addr;
                    end
                end
            end
            RD_ISSUE: begin
                if (read_go && mem_ready) begin
                    st_d.rs = RD_WAIT;
                end
            end
            RD_WAIT: begin
                if (mem_rvalid) begin
                    st_d.rsp_v = 1'b1;
                    st_d.rsp_d = mem_rdata;
                    st_d.rs    = RD_IDLE;
                end
            end
            default: st_d.rs = RD_IDLE;
        endcase
    end

    assign rd_ready  = (st_q.rs == RD_IDLE);
    assign rsp_valid = st_q.rsp_v;
    assign rsp_data  = st_q.rsp_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.rs <= RD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_rd_empty,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              full, empty, push, pop, hit;
    logic [DATA_W-1:0] hit_data;
    logic              ord_vld  [DEPTH];
    logic [ADDR_W-1:0] ord_addr [DEPTH];
    logic [DATA_W-1:0] ord_data [DEPTH];

    assign st_ready = !full;
    assign push     = st_valid && !full;

    wbuf_fifo #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (pop),
        .full      (full),
        .empty     (empty),
        .ord_vld   (ord_vld),
        .ord_addr  (ord_addr),
        .ord_data  (ord_data)
    );

    wbuf_match #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) u_match (
        .ord_vld   (ord_vld),
        .ord_addr  (ord_addr),
        .ord_data  (ord_data),
        .q_addr    (rd_addr),
        .hit       (hit),
        .hit_data  (hit_data)
    );

    wbuf_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold_rd_empty (hold_rd_empty),
        .rd_valid      (rd_valid),
        .rd_addr       (rd_addr),
        .rd_ready      (rd_ready),
        .hit           (hit),
        .hit_data      (hit_data),
        .q_empty       (empty),
        .head_addr     (ord_addr[0]),
        .head_data     (ord_data[0]),
        .pop           (pop),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .mem_valid     (mem_valid),
        .mem_ready     (mem_ready),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata)
    );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          rd_ready,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_rvalid,
    input logic [DW-1:0] mem_rdata
);
    localparam int unsigned OW = $clog2(DEPTH + 1) + 1;

    logic [OW-1:0] occ;
    logic          rd_out;
    logic          st_fire, wr_fire, rdm_fire;

    assign st_fire  = st_valid && st_ready;
    assign wr_fire  = mem_valid && mem_ready && mem_we;
    assign rdm_fire = mem_valid && mem_ready && !mem_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ    <= '0;
            rd_out <= 1'b0;
        end else begin
            case ({st_fire, wr_fire})
                2'b10:   occ <= occ + OW'(1);
                2'b01:   occ <= occ - OW'(1);
                default: occ <= occ;
            endcase
            if (rdm_fire)        rd_out <= 1'b1;
            else if (mem_rvalid) rd_out <= 1'b0;
        end
    end

    assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(DEPTH));
    assert_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OW'(DEPTH)) |-> !st_ready);
    assert_space_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < OW'(DEPTH)) |-> st_ready);
    assert_drain_needs_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> (occ != '0));
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) &&
                                       $stable(mem_addr) && $stable(mem_wdata)));
    assert_no_drain_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out |-> !(mem_valid && mem_we));
    assert_rsp_from_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out && mem_rvalid) |=> (rsp_valid && rsp_data == $past(mem_rdata)));
    assert_busy_after_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdm_fire |=> !rd_ready);
endmodule

bind wbuf_fwd wbuf_chk #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .rd_ready   (rd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
);

// File: tb/sim_wbuf_fwd.sv
`timescale 1ns/1ps
module sim_wbuf_fwd;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_rd_empty = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [15:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [15:0] rd_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    wbuf_fwd #(.ADDR_W(16), .DATA_W(32), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .hold_rd_empty(hold_rd_empty),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    typedef struct { logic [15:0] a; logic [31:0] d; } ent_t;
    ent_t            mq[$];
    logic [31:0]     mem_arr[int];
    int              ms = 0;            // 0 idle, 1 waiting for port, 2 waiting for data
    logic [15:0]     m_raddr = '0;
    bit              m_lwr = 0, m_lrd = 0;
    bit              m_rv = 0;
    logic [31:0]     m_rd = '0;
    string           m_rtag = "R5";
    int              pend = -1;
    logic [31:0]     pend_val = '0;
    int              writes_done = 0, mem_reads = 0, cnt_at_read = 0;
    bit              p_valid = 0, p_ready = 0;
    logic [15:0]     p_addr = '0;
    int              rdy_mode = 0;

    function automatic logic [31:0] memval(input logic [15:0] a);
        if (mem_arr.exists(int'(a))) return mem_arr[int'(a)];
        return {16'hA5A5, a};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            int  cnt, ms_n;
            bit  rgo, dgo, nrv, hit;
            logic [31:0] nrd;
            string mtag;
            if (pend > 0) pend--;
            cnt  = mq.size();
            rgo  = (ms == 1) && (m_lrd || (!m_lwr && !(hold_rd_empty && cnt != 0)));
            dgo  = (cnt != 0) && (ms != 2) && !rgo;
            mtag = hold_rd_empty ? "R8" : (rgo ? "R6" : "R3");
            chk(st_ready == (cnt < DEPTH), "R2 st_ready", 32'(st_ready), 32'(cnt < DEPTH));
            chk(rd_ready == (ms == 0), "R9 rd_ready", 32'(rd_ready), 32'(ms == 0));
            chk(mem_valid == (rgo || dgo), {mtag, " mem_valid"}, 32'(mem_valid), 32'(rgo || dgo));
            if (rgo || dgo) begin
                chk(mem_we == dgo, {mtag, " mem_we"}, 32'(mem_we), 32'(dgo));
                chk(mem_addr == (rgo ? m_raddr : mq[0].a), {mtag, " mem_addr"},
                    32'(mem_addr), 32'(rgo ? m_raddr : mq[0].a));
                if (dgo) chk(mem_wdata == mq[0].d, "R3 mem_wdata", mem_wdata, mq[0].d);
            end
            if (p_valid && !p_ready)
                chk(mem_valid && mem_addr == p_addr, "R4 held request", 32'(mem_addr), 32'(p_addr));
            chk(rsp_valid == m_rv, {m_rtag, " rsp_valid"}, 32'(rsp_valid), 32'(m_rv));
            if (m_rv) chk(rsp_data == m_rd, {m_rtag, " rsp_data"}, rsp_data, m_rd);

            // advance to the state after the coming edge
            ms_n = ms; nrv = 0; nrd = m_rd; hit = 0;
            if (ms == 0 && rd_valid) begin
                for (int i = mq.size() - 1; i >= 0; i--) begin
                    if (!hit && mq[i].a == rd_addr) begin
                        hit = 1; nrd = mq[i].d;
                    end
                end
                if (hit) begin nrv = 1; m_rtag = "R5"; end
                else begin ms_n = 1; m_raddr = rd_addr; end
            end
            if (ms == 1 && rgo && mem_ready) begin
                ms_n = 2; pend = 2; pend_val = memval(m_raddr);
                mem_reads++; cnt_at_read = cnt;
            end
            if (ms == 2 && mem_rvalid) begin
                nrv = 1; nrd = mem_rdata; m_rtag = "R7"; ms_n = 0; pend = -1;
            end
            m_lwr = dgo && !mem_ready;
            m_lrd = rgo && !mem_ready;
            if (dgo && mem_ready) begin
                mem_arr[int'(mq[0].a)] = mq[0].d;
                void'(mq.pop_front());
                writes_done++;
            end
            if (st_valid && cnt < DEPTH) mq.push_back('{a: st_addr, d: st_data});
            ms = ms_n; m_rv = nrv; m_rd = nrd;
            p_valid = mem_valid; p_ready = mem_ready; p_addr = mem_addr;
        end
    end

    // memory side drive
    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0:       mem_ready = 1'b1;
            1:       mem_ready = ($urandom % 3) != 0;
            default: mem_ready = 1'b0;
        endcase
        mem_rvalid = (pend == 0);
        mem_rdata  = (pend == 0) ? pend_val : 32'h0;
    end

    // ---------------- stimulus tasks ----------------
    task automatic do_store(input logic [15:0] a, input logic [31:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d;
        forever begin @(negedge clk); if (st_ready) break; end
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [31:0] d);
        rd_valid = 1'b1; rd_addr = a;
        forever begin @(negedge clk); if (rd_ready) break; end
        @(posedge clk); #1;
        rd_valid = 1'b0;
        forever begin @(negedge clk); if (rsp_valid) break; end
        d = rsp_data;
        @(posedge clk); #1;
    endtask

    task automatic wait_idle();
        forever begin @(negedge clk); if (mq.size() == 0 && ms == 0 && !m_rv) break; end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int r0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(st_ready == 1'b1, "R1 st_ready", 32'(st_ready), 1);
        chk(rd_ready == 1'b1, "R1 rd_ready", 32'(rd_ready), 1);
        chk(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
        @(posedge clk); #1;

        // fill with memory stalled, repeated addresses
        rdy_mode = 2;
        @(posedge clk); #1;
        do_store(16'h0010, 32'h1111_0001);
        do_store(16'h0020, 32'h2222_0002);
        do_store(16'h0010, 32'h1111_0003);
        do_store(16'h0030, 32'h3333_0004);
        @(negedge clk);
        chk(st_ready == 1'b0, "R2 full stall", 32'(st_ready), 0);
        @(posedge clk); #1;

        // forwarding: youngest match wins, no memory read
        r0 = mem_reads;
        do_read(16'h0010, d);
        chk(d == 32'h1111_0003, "R5 youngest forward", d, 32'h1111_0003);
        do_read(16'h0020, d);
        chk(d == 32'h2222_0002, "R5 single forward", d, 32'h2222_0002);
        chk(mem_reads == r0, "R5 no memory read", 32'(mem_reads), 32'(r0));

        // unmatched read overtakes pending drains
        rdy_mode = 0;
        do_read(16'h0055, d);
        chk(cnt_at_read > 0, "R6 read ahead of drains", 32'(cnt_at_read), 1);
        chk(d == 32'hA5A5_0055, "R7 memory data", d, 32'hA5A5_0055);
        wait_idle();

        // drain order: last store to 0x10 must be in memory
        do_read(16'h0010, d);
        chk(d == 32'h1111_0003, "R3 drain order", d, 32'h1111_0003);

        // hold mode: unmatched read waits for empty queue
        hold_rd_empty = 1'b1;
        rdy_mode = 2;
        @(posedge clk); #1;
        do_store(16'h0040, 32'h4444_0001);
        do_store(16'h0041, 32'h4444_0002);
        do_store(16'h0042, 32'h4444_0003);
        rdy_mode = 0;
        do_read(16'h0077, d);
        chk(cnt_at_read == 0, "R8 issued only when empty", 32'(cnt_at_read), 0);
        chk(d == 32'hA5A5_0077, "R8 memory data", d, 32'hA5A5_0077);
        wait_idle();

        // mixed traffic, random stalls, both modes
        for (int pass = 0; pass < 2; pass++) begin
            hold_rd_empty = (pass == 1);
            rdy_mode = 1;
            fork
                begin
                    for (int i = 0; i < 150; i++) begin
                        do_store(16'h0100 + 16'($urandom % 6), $urandom);
                        if ($urandom % 2 == 0) begin @(posedge clk); #1; end
                    end
                end
                begin
                    for (int i = 0; i < 60; i++) begin
                        logic [31:0] dd;
                        do_read(16'h0100 + 16'($urandom % 8), dd);
                    end
                end
            join
            rdy_mode = 0;
            wait_idle();
        end

        repeat (3) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule